// File: doc/BRIEF.md
# Transaction Packet Receive Decoder

This block sits on the receive side of a serial-bus endpoint. It watches a stream of 64-bit beats, each split into two 32-bit dwords with the earlier dword in bits 63:32. A start flag marks the first beat of a packet and an end flag marks the last. A qualifier strobe marks the beats that carry data, and beats without it may appear anywhere. The block picks out three kinds of packet: memory reads and memory writes that use a three-dword header with a 32-bit address, and completions that carry data. For each one it issues a one-cycle strobe together with a data word, a qword address and a 5-bit tag.

Because the header is three dwords long, write data and completion payload start in the lower half of a beat. The block therefore joins dwords across beat boundaries to form 64-bit words. A completion with several payload dwords gives one strobe per joined pair. The requester identity of the most recent accepted read is kept on a separate output, so that a responder can address its reply. A region-hit input decides whether read and write requests are acted on.

Top module: `tlp_rx_decode`

## Requirements
- R1: While reset is applied and after it is released, all three strobes are low and the data, address, tag and requester-identity outputs are zero.
- R2: A first beat whose header marks a memory read (format bits 62:61 = 00, type bits 60:56 = 00000) loads `reqId` from beat bits 31:16, visible in the cycle after that beat. Writes and completions leave `reqId` unchanged.
- R3: For a read, the next valid beat holds the address dword in bits 63:32. One cycle after that beat, `rdStb` is high for one cycle with `outData` zero, `outAddr` equal to address-dword bits 31:3 (upper bits zero) and `outTag` equal to header bits 12:8 of the first beat.
- R4: For a write (format 10, type 00000), the second valid beat holds the address dword (upper) and the high data dword (lower), and the third valid beat holds the low data dword in its upper half. One cycle after the third beat, `wrStb` is high with `outData` = {high, low}, the address taken as in R3, and the header tag.
- R5: For a completion (format 10, type 01010), the upper dword of the second beat carries the tag in bits 44:40, and its lower dword is the first payload dword. Payload dwords, counted by header bits 41:32, are paired in order into 64-bit words with the earlier dword high. Each word gives a one-cycle `cplStb` one cycle after the beat that completes it, with `outAddr` zero and the completion tag.
- R6: A beat with `beatValid` low is ignored whatever its other inputs are: it starts no packet, changes no state, and any partly assembled word is kept.
- R7: Payload dwords beyond the header length count, and any further beats up to the end flag, produce no strobe.
- R8: At most one of `rdStb`, `wrStb` and `cplStb` is high in any cycle.
- R9: A read or write whose first beat arrives with `barHit` low produces no strobe and does not change `reqId`. Completions are decoded whatever `barHit` is.
- R10: A packet with any other format/type pair is skipped up to its end-flagged beat. Its beats start nothing, even when one of them looks like a header.
- R11: `outData`, `outAddr` and `outTag` change only in cycles in which a strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| beat | input | 64 | Incoming beat, earlier dword in bits 63:32 |
| beatSof | input | 1 | Beat is the first of a packet |
| beatEof | input | 1 | Beat is the last of a packet |
| beatValid | input | 1 | Beat carries data |
| barHit | input | 1 | Requests target this endpoint's region |
| rdStb | output | 1 | Memory read decoded (one cycle) |
| wrStb | output | 1 | Memory write decoded (one cycle) |
| cplStb | output | 1 | Completion payload word ready (one cycle) |
| outData | output | 64 | Write data or completion payload word |
| outAddr | output | 61 | Qword address, bits 63:3 |
| outTag | output | 5 | Transaction tag |
| reqId | output | 16 | Requester identity of the last accepted read |

## Verification
On every cycle the assertions check the following: the three strobes are mutually exclusive, the outputs hold their values between strobes, a read carries zero data and a 32-bit address, a completion carries a zero address, and `reqId` does not move when a write or completion strobe fires. Only the bench scenarios can show the rest. That covers the exact cycle of each strobe, the joining of dwords across beats and across invalid beats, the count of strobes a completion length gives, dropped trailing payload, the effect of the region-hit input and the skipping of unknown packets.

// File: rtl/tlp_rx_pkg.sv
package tlp_rx_pkg;
  localparam int BEAT_W   = 64;
  localparam int DW_W     = 32;
  localparam int ID_W     = 16;
  localparam int TAG_W    = 5;
  localparam int LEN_W    = 10;
  localparam int QW_SHIFT = 3;
  localparam int ADDR_W   = BEAT_W - QW_SHIFT;

  // header field positions inside the first beat
  localparam int FMT_LSB  = 61;
  localparam int TYPE_LSB = 56;
  localparam int LEN_LSB  = 32;
  localparam int ID_LSB   = 16;
  localparam int TAG_LSB  = 8;
  localparam int CTAG_LSB = DW_W + TAG_LSB;

  localparam logic [1:0] FMT_NODATA = 2'b00;
  localparam logic [1:0] FMT_DATA   = 2'b10;
  localparam logic [4:0] TYP_MEM    = 5'b00000;
  localparam logic [4:0] TYP_CPL    = 5'b01010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_ADDR, ST_WR_ADDR, ST_WR_LO, ST_CPL_ID, ST_CPL_DATA, ST_DRAIN
  } rxState_t;

  typedef struct packed {
    logic ldReqId;
    logic ldTag;
    logic tagFromCpl;
    logic ldAddr;
    logic ldDataHi;
    logic holdUpper;
    logic holdLower;
    logic emitRd;
    logic emitWr;
    logic emitCpl;
    logic cplFromBeat;
  } dpCtl_t;
endpackage

// File: rtl/tlp_rx_ctrl.sv
module tlp_rx_ctrl
  import tlp_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             beatValid,
  input  logic             beatSof,
  input  logic             beatEof,
  input  logic             barHit,
  input  logic [1:0]       hdrFmt,
  input  logic [4:0]       hdrType,
  input  logic [LEN_W-1:0] hdrLen,
  output dpCtl_t           ctl
);
  rxState_t         state, stateD;
  logic [LEN_W-1:0] remQ, remD;
  logic             halfQ, halfD;
  logic             barQ, barD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      remQ  <= '0;
      halfQ <= 1'b0;
      barQ  <= 1'b0;
    end else begin
      state <= stateD;
      remQ  <= remD;
      halfQ <= halfD;
      barQ  <= barD;
    end
  end

  always_comb begin
    ctl    = '0;
    stateD = state;
    remD   = remQ;
    halfD  = halfQ;
    barD   = barQ;
    if (beatValid) begin
      unique case (state)
        ST_IDLE: begin
          if (beatSof) begin
            barD = barHit;
            if (hdrFmt == FMT_NODATA && hdrType == TYP_MEM) begin
              ctl.ldTag   = 1'b1;
              ctl.ldReqId = barHit;
              stateD      = ST_RD_ADDR;
            end else if (hdrFmt == FMT_DATA && hdrType == TYP_MEM) begin
              ctl.ldTag = 1'b1;
              stateD    = ST_WR_ADDR;
            end else if (hdrFmt == FMT_DATA && hdrType == TYP_CPL) begin
              remD   = hdrLen;
              halfD  = 1'b0;
              stateD = ST_CPL_ID;
            end else begin
              stateD = ST_DRAIN;
            end
            if (beatEof) stateD = ST_IDLE;
          end
        end
        ST_RD_ADDR: begin
          ctl.emitRd = barQ;
          stateD     = beatEof ? ST_IDLE : ST_DRAIN;
        end
        ST_WR_ADDR: begin
          ctl.ldAddr   = 1'b1;
          ctl.ldDataHi = 1'b1;
          stateD       = beatEof ? ST_IDLE : ST_WR_LO;
        end
        ST_WR_LO: begin
          ctl.emitWr = barQ;
          stateD     = beatEof ? ST_IDLE : ST_DRAIN;
        end
        ST_CPL_ID: begin
          ctl.ldTag      = 1'b1;
          ctl.tagFromCpl = 1'b1;
          if (remQ != '0) begin
            ctl.holdLower = 1'b1;
            halfD         = 1'b1;
            remD          = remQ - LEN_W'(1);
          end
          stateD = beatEof ? ST_IDLE : ((remD == '0) ? ST_DRAIN : ST_CPL_DATA);
        end
        ST_CPL_DATA: begin
          if (remQ != '0) begin
            if (halfQ) begin
              ctl.emitCpl = 1'b1;
              if (remQ >= LEN_W'(2)) begin
                ctl.holdLower = 1'b1;
                remD          = remQ - LEN_W'(2);
              end else begin
                halfD = 1'b0;
                remD  = remQ - LEN_W'(1);
              end
            end else if (remQ >= LEN_W'(2)) begin
              ctl.emitCpl     = 1'b1;
              ctl.cplFromBeat = 1'b1;
              remD            = remQ - LEN_W'(2);
            end else begin
              ctl.holdUpper = 1'b1;
              halfD         = 1'b1;
              remD          = remQ - LEN_W'(1);
            end
          end
          stateD = beatEof ? ST_IDLE : ((remD == '0) ? ST_DRAIN : ST_CPL_DATA);
        end
        ST_DRAIN: begin
          if (beatEof) stateD = ST_IDLE;
        end
        default: stateD = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tlp_rx_dpath.sv
module tlp_rx_dpath
  import tlp_rx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [BEAT_W-1:0]     beat,
  input  dpCtl_t                ctl,
  output logic [1:0]            hdrFmt,
  output logic [4:0]            hdrType,
  output logic [LEN_W-1:0]      hdrLen,
  output logic                  rdStb,
  output logic                  wrStb,
  output logic                  cplStb,
  output logic [BEAT_W-1:0]     outData,
  output logic [BEAT_W-1:QW_SHIFT] outAddr,
  output logic [TAG_W-1:0]      outTag,
  output logic [ID_W-1:0]       reqId
);
  localparam int AQ_W  = DW_W - QW_SHIFT;
  localparam int PAD_W = ADDR_W - AQ_W;

  logic [TAG_W-1:0] tagQ;
  logic [AQ_W-1:0]  addrQ;
  logic [DW_W-1:0]  hiQ;
  logic [DW_W-1:0]  heldQ;
  logic [DW_W-1:0]  upperDw;
  logic [DW_W-1:0]  lowerDw;

  assign upperDw = beat[BEAT_W-1:DW_W];
  assign lowerDw = beat[DW_W-1:0];
  assign hdrFmt  = beat[FMT_LSB +: 2];
  assign hdrType = beat[TYPE_LSB +: 5];
  assign hdrLen  = beat[LEN_LSB +: LEN_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagQ    <= '0;
      addrQ   <= '0;
      hiQ     <= '0;
      heldQ   <= '0;
      reqId   <= '0;
      rdStb   <= 1'b0;
      wrStb   <= 1'b0;
      cplStb  <= 1'b0;
      outData <= '0;
      outAddr <= '0;
      outTag  <= '0;
    end else begin
      if (ctl.ldReqId)  reqId <= beat[ID_LSB +: ID_W];
      if (ctl.ldTag)    tagQ  <= ctl.tagFromCpl ? beat[CTAG_LSB +: TAG_W] : beat[TAG_LSB +: TAG_W];
      if (ctl.ldAddr)   addrQ <= upperDw[DW_W-1:QW_SHIFT];
      if (ctl.ldDataHi) hiQ   <= lowerDw;
      if (ctl.holdUpper)      heldQ <= upperDw;
      else if (ctl.holdLower) heldQ <= lowerDw;
      rdStb  <= ctl.emitRd;
      wrStb  <= ctl.emitWr;
      cplStb <= ctl.emitCpl;
      if (ctl.emitRd) begin
        outData <= '0;
        outAddr <= {{PAD_W{1'b0}}, upperDw[DW_W-1:QW_SHIFT]};
        outTag  <= tagQ;
      end else if (ctl.emitWr) begin
        outData <= {hiQ, upperDw};
        outAddr <= {{PAD_W{1'b0}}, addrQ};
        outTag  <= tagQ;
      end else if (ctl.emitCpl) begin
        outData <= ctl.cplFromBeat ? beat : {heldQ, upperDw};
        outAddr <= '0;
        outTag  <= tagQ;
      end
    end
  end
endmodule

// File: rtl/tlp_rx_decode.sv
module tlp_rx_decode
  import tlp_rx_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [BEAT_W-1:0]        beat,
  input  logic                     beatSof,
  input  logic                     beatEof,
  input  logic                     beatValid,
  input  logic                     barHit,
  output logic                     rdStb,
  output logic                     wrStb,
  output logic                     cplStb,
  output logic [BEAT_W-1:0]        outData,
  output logic [BEAT_W-1:QW_SHIFT] outAddr,
  output logic [TAG_W-1:0]         outTag,
  output logic [ID_W-1:0]          reqId
);
  dpCtl_t           ctl;
  logic [1:0]       hdrFmt;
  logic [4:0]       hdrType;
  logic [LEN_W-1:0] hdrLen;

  tlp_rx_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .beatValid(beatValid), .beatSof(beatSof),
    .beatEof(beatEof), .barHit(barHit), .hdrFmt(hdrFmt), .hdrType(hdrType),
    .hdrLen(hdrLen), .ctl(ctl)
  );

  tlp_rx_dpath dpath_i (
    .clk(clk), .rstN(rstN), .beat(beat), .ctl(ctl), .hdrFmt(hdrFmt),
    .hdrType(hdrType), .hdrLen(hdrLen), .rdStb(rdStb), .wrStb(wrStb),
    .cplStb(cplStb), .outData(outData), .outAddr(outAddr), .outTag(outTag),
    .reqId(reqId)
  );
endmodule

// File: rtl/tlp_rx_chk.sv
module tlp_rx_chk (
  input logic        clk,
  input logic        rstN,
  input logic        rdStb,
  input logic        wrStb,
  input logic        cplStb,
  input logic [63:0] outData,
  input logic [63:3] outAddr,
  input logic [4:0]  outTag,
  input logic [15:0] reqId
);
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdStb, wrStb, cplStb}));

  p_hold_outputs_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!rdStb && !wrStb && !cplStb) |-> ($stable(outData) && $stable(outAddr) && $stable(outTag)));

  p_read_shape_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdStb |-> (outData == 64'd0 && outAddr[63:32] == 32'd0));

  p_write_addr_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |-> (outAddr[63:32] == 32'd0));

  p_cpl_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    cplStb |-> (outAddr == 61'd0));

  p_reqid_kept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb || cplStb) |-> $stable(reqId));
endmodule

bind tlp_rx_decode tlp_rx_chk chk_i (.*);

// File: tb/tlp_rx_decode_tb_top.sv
module tlp_rx_decode_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] beat = '0;
  logic        beatSof = 1'b0, beatEof = 1'b0, beatValid = 1'b0, barHit = 1'b1;
  logic        rdStb, wrStb, cplStb;
  logic [63:0] outData;
  logic [63:3] outAddr;
  logic [4:0]  outTag;
  logic [15:0] reqId;

  always #5 clk = ~clk;

  tlp_rx_decode dut_i (.*);

  typedef struct {
    int          kind;   // 1 read, 2 write, 3 completion
    logic [63:0] data;
    logic [60:0] addr;
    logic [4:0]  tag;
    int          due;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          cyc = 0;
  int          checks = 0;
  int          bad = 0;
  bit          monOn = 0;
  bit          pendOn = 0;
  logic [15:0] pendId = '0;
  logic [15:0] expReqId = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] ex);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, ex);
    end
  endtask

  function automatic logic [63:0] hdr(logic [1:0] f, logic [4:0] t, logic [9:0] len,
                                      logic [15:0] id, logic [7:0] tg);
    return {1'b0, f, t, 8'h00, 6'h00, len, id, tg, 8'hFF};
  endfunction

  task automatic drive(logic [63:0] d, bit s, bit e, bit v);
    @(posedge clk); #1;
    if (pendOn) begin expReqId = pendId; pendOn = 0; end
    beat = d; beatSof = s; beatEof = e; beatValid = v;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive('0, 0, 0, 0);
  endtask

  task automatic expect_item(int k, logic [63:0] d, logic [60:0] a, logic [4:0] t, string req);
    exp_t e;
    e.kind = k; e.data = d; e.addr = a; e.tag = t; e.due = cyc + 1; e.req = req;
    sb.push_back(e);
  endtask

  // monitor: compare strobes against the scoreboard away from the active edge
  always @(negedge clk) begin
    exp_t e;
    int   act;
    if (monOn) begin
      chk(reqId == expReqId, "R2", "reqId", 64'(reqId), 64'(expReqId));
      chk($countones({rdStb, wrStb, cplStb}) <= 1, "R8", "strobe count",
          64'({rdStb, wrStb, cplStb}), 64'd0);
      if (rdStb || wrStb || cplStb) begin
        act = rdStb ? 1 : (wrStb ? 2 : 3);
        if (sb.size() == 0) begin
          chk(0, "R7", "unexpected strobe", 64'(act), 64'd0);
        end else begin
          e = sb.pop_front();
          chk(act == e.kind, e.req, "kind", 64'(act), 64'(e.kind));
          chk(cyc == e.due, e.req, "cycle", 64'(cyc), 64'(e.due));
          chk(outData == e.data, e.req, "data", outData, e.data);
          chk(outAddr == e.addr, e.req, "addr", 64'(outAddr), 64'(e.addr));
          chk(outTag == e.tag, e.req, "tag", 64'(outTag), 64'(e.tag));
        end
      end else if (sb.size() > 0 && sb[0].due <= cyc) begin
        e = sb.pop_front();
        chk(0, e.req, "missing strobe", 64'(cyc), 64'(e.due));
      end
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, bad);
  endtask

  initial begin
    #(200000 * 10);
    checks++; bad++;
    $display("FAIL watchdog expired: actual=%0d expected=done", cyc);
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({rdStb, wrStb, cplStb} == 3'b000, "R1", "strobes in reset", 64'({rdStb, wrStb, cplStb}), 0);
    chk(outData == 0 && outAddr == 0 && outTag == 0 && reqId == 0, "R1", "outputs in reset",
        outData, 0);
    @(posedge clk); #1 rstN = 1'b1;
    monOn = 1;
    idle(2);
    chk(reqId == 0 && outData == 0, "R1", "after release", 64'(reqId), 0);

    // R3 / R2: read with unaligned-looking address
    drive(hdr(2'b00, 5'b00000, 10'd2, 16'hAAAA, 8'h0A), 1, 0, 1);
    pendId = 16'hAAAA; pendOn = 1;
    drive({32'h1234_5678, 32'h0}, 0, 1, 1);
    expect_item(1, 64'd0, 61'(32'h1234_5678 >> 3), 5'h0A, "R3");

    // R4: write immediately after, reqId kept (R2)
    drive(hdr(2'b10, 5'b00000, 10'd2, 16'hBBBB, 8'h05), 1, 0, 1);
    drive({32'h0000_0010, 32'hAAAA_AAAA}, 0, 0, 1);
    drive({32'h5555_5555, 32'hDEAD_BEEF}, 0, 1, 1);
    expect_item(2, 64'hAAAA_AAAA_5555_5555, 61'd2, 5'h05, "R4");
    idle(1);

    // R6: write with invalid beats between, some carrying header-like content
    drive(hdr(2'b10, 5'b00000, 10'd2, 16'hCCCC, 8'h13), 1, 0, 1);
    drive(hdr(2'b00, 5'b00000, 10'd1, 16'h7777, 8'h01), 1, 0, 0);
    idle(1);
    drive({32'h0000_0100, 32'h0F0F_0F0F}, 0, 0, 1);
    idle(3);
    drive({32'hF0F0_F0F0, 32'h0}, 0, 1, 1);
    expect_item(2, 64'h0F0F_0F0F_F0F0_F0F0, 61'h20, 5'h13, "R6");

    // R6: invalid read header in idle starts nothing, reqId kept
    drive(hdr(2'b00, 5'b00000, 10'd1, 16'h9999, 8'h02), 1, 0, 0);
    drive({32'h0000_0040, 32'h0}, 0, 1, 0);
    idle(2);

    // R5: completion of four dwords with a gap and trailing dword (R7)
    drive(hdr(2'b10, 5'b01010, 10'd4, 16'hBBBB, 8'h04), 1, 0, 1);
    drive({16'hBBBB, 8'h0B, 8'h00, 32'h1111_1111}, 0, 0, 1);
    drive({32'h2222_2222, 32'h3333_3333}, 0, 0, 1);
    expect_item(3, 64'h1111_1111_2222_2222, 61'd0, 5'h0B, "R5");
    idle(1);
    drive({32'h4444_4444, 32'h0123_4567}, 0, 1, 1);
    expect_item(3, 64'h3333_3333_4444_4444, 61'd0, 5'h0B, "R5");
    idle(2);

    // R9: completion decoded with region-hit low, six dwords, three words
    barHit = 1'b0;
    drive(hdr(2'b10, 5'b01010, 10'd6, 16'h1111, 8'h00), 1, 0, 1);
    drive({16'h2222, 8'hFF, 8'h00, 32'hA000_0000}, 0, 0, 1);
    drive({32'hA000_0001, 32'hA000_0002}, 0, 0, 1);
    expect_item(3, 64'hA000_0000_A000_0001, 61'd0, 5'h1F, "R9");
    drive({32'hA000_0003, 32'hA000_0004}, 0, 0, 1);
    expect_item(3, 64'hA000_0002_A000_0003, 61'd0, 5'h1F, "R5");
    drive({32'hA000_0005, 32'hBAD0_BAD0}, 0, 1, 1);
    expect_item(3, 64'hA000_0004_A000_0005, 61'd0, 5'h1F, "R5");

    // R9: read and write with region-hit low do nothing
    drive(hdr(2'b00, 5'b00000, 10'd2, 16'hCAFE, 8'h03), 1, 0, 1);
    drive({32'h0000_0800, 32'h0}, 0, 1, 1);
    drive(hdr(2'b10, 5'b00000, 10'd2, 16'hCAFE, 8'h03), 1, 0, 1);
    drive({32'h0000_0800, 32'h1}, 0, 0, 1);
    drive({32'h2, 32'h0}, 0, 1, 1);
    idle(2);
    barHit = 1'b1;

    // R7: completion of two dwords followed by extra beats
    drive(hdr(2'b10, 5'b01010, 10'd2, 16'h0000, 8'h00), 1, 0, 1);
    drive({16'h0000, 8'h07, 8'h00, 32'hC0DE_0001}, 0, 0, 1);
    drive({32'hC0DE_0002, 32'hEEEE_EEEE}, 0, 0, 1);
    expect_item(3, 64'hC0DE_0001_C0DE_0002, 61'd0, 5'h07, "R7");
    drive({32'hEEEE_EEEE, 32'hEEEE_EEEE}, 0, 0, 1);
    drive({32'hEEEE_EEEE, 32'hEEEE_EEEE}, 0, 1, 1);
    idle(2);

    // R10: unknown packet with a header-like middle beat
    drive(hdr(2'b01, 5'b00100, 10'd1, 16'h5A5A, 8'h01), 1, 0, 1);
    drive(hdr(2'b00, 5'b00000, 10'd1, 16'hDDDD, 8'h06), 0, 0, 1);
    drive({32'h0000_0080, 32'h0}, 0, 1, 1);
    idle(1);

    // R2: a later read updates reqId; back-to-back with a completion
    drive(hdr(2'b00, 5'b00000, 10'd2, 16'h1234, 8'h1E), 1, 0, 1);
    pendId = 16'h1234; pendOn = 1;
    drive({32'hFFFF_FFF8, 32'h0}, 0, 1, 1);
    expect_item(1, 64'd0, 61'(32'hFFFF_FFF8 >> 3), 5'h1E, "R3");
    drive(hdr(2'b10, 5'b01010, 10'd2, 16'h4321, 8'h00), 1, 0, 1);
    drive({16'h4321, 8'h11, 8'h00, 32'h0000_00AA}, 0, 0, 1);
    drive({32'h0000_00BB, 32'h0}, 0, 1, 1);
    expect_item(3, 64'h0000_00AA_0000_00BB, 61'd0, 5'h11, "R5");
    idle(4);

    chk(sb.size() == 0, "R5", "pending expectations", 64'(sb.size()), 0);
    chk(outData == 64'h0000_00AA_0000_00BB && outTag == 5'h11, "R11", "held outputs",
        outData, 64'h0000_00AA_0000_00BB);
    summary();
    $finish;
  end
endmodule